// File: doc/BRIEF.md
# Clock-Loss Monitor with Failover

This block watches a main oscillator from the domain of an always-running backup oscillator. Each main clock edge flips a toggle flop. The toggle is passed through a two-flop synchronizer into the backup domain, and every change seen there counts as one main-clock edge. A long run of backup cycles with no edge means the main clock has stopped. A short burst of closely spaced edges after a stop means it has started again.

A mode bit chooses what a stop does:
- **Reset mode (0):** the block raises a reset request and halts. Only the external hardware reset clears it.
- **Interrupt mode (1):** the block pulses an interrupt and sets a sticky detect flag and a live "main stopped" flag. If the main clock was the CPU clock source, it also moves the clock-source selector to the backup clock.

A restart in interrupt mode pulses the interrupt again, sets the detect flag and clears the stopped flag. It leaves the selector alone. Software clears the detect flag through a dedicated clear strobe.

The monitor is one state machine with four states:
- `MON_OFF`: monitor disabled.
- `MON_RUN`: main clock present.
- `MON_LOST`: main clock absent, interrupt mode.
- `MON_HALT`: reset request held.

Its transitions are:
- *enable*: OFF to RUN.
- *disable*: RUN or LOST to OFF.
- *stop*: RUN to LOST in interrupt mode.
- *restart*: LOST to RUN.
- *halt*: a stop in reset mode, RUN to HALT. A restart in reset mode, LOST to HALT, is also wired, but reset mode must never be programmed while the main clock is lost.

Top module: `clk_loss_monitor`

## Requirements
- R1: After hardware reset, `mon_en`, `mon_mode`, `src_sel` (2'b00), `det_flag`, `main_stopped`, `osc_irq` and `sys_rst_req` are all 0.
- R2: While `mon_en` is 0, starting or stopping the main clock causes no `osc_irq` pulse, no `sys_rst_req` and no change of `det_flag` or `main_stopped`.
- R3: A stop is declared only after 8 consecutive backup-clock cycles without a synchronized main-clock edge. No stop is declared within 8 backup cycles of the main clock halting.
- R4: In interrupt mode (`mon_mode`=1), a stop gives exactly one single-cycle `osc_irq` pulse and sets `det_flag`=1 and `main_stopped`=1.
- R5: `src_sel` encodes the clock source: 2'b00 main, 2'b01 PLL, 2'b10 backup. In interrupt mode, a stop while `src_sel`=2'b00 forces `src_sel` to 2'b10.
- R6: In interrupt mode, a stop while `src_sel`=2'b01 leaves `src_sel` at 2'b01.
- R7: In the stopped state, a restart is declared after 4 synchronized main-clock edges, each within 8 backup cycles of the previous one. A restart gives one `osc_irq` pulse, sets `det_flag`=1, clears `main_stopped` and leaves `src_sel` unchanged.
- R8: In reset mode (`mon_mode`=0), a stop raises `sys_rst_req` without `osc_irq`. The request stays high, and configuration writes are ignored, until `rst_n` is asserted. Programming reset mode while the monitor is in the stopped state is illegal.
- R9: A `det_clr` pulse clears `det_flag`. A hardware set of `det_flag` in the same cycle wins.
- R10: A `cfg_wr` pulse loads `mon_en`, `mon_mode` and `src_sel` from `cfg_en`, `cfg_mode` and `cfg_src`. A hardware force of `src_sel` to backup in the same cycle wins.
- R11: Clearing `mon_en` while the main clock is lost returns `main_stopped` to 0. A later restart then produces no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bk_clk | input | 1 | Backup oscillator clock, always running |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| main_clk | input | 1 | Monitored main oscillator clock |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value to write |
| cfg_mode | input | 1 | Mode value to write (0 reset, 1 interrupt) |
| cfg_src | input | 2 | Clock-source selector value to write |
| det_clr | input | 1 | Clear strobe for the detect flag |
| mon_en | output | 1 | Current enable bit |
| mon_mode | output | 1 | Current mode bit |
| src_sel | output | 2 | Clock-source selector (00 main, 01 PLL, 10 backup) |
| det_flag | output | 1 | Sticky stop/restart detected flag |
| main_stopped | output | 1 | Main clock currently considered stopped |
| osc_irq | output | 1 | Single-cycle stop/restart interrupt pulse |
| sys_rst_req | output | 1 | Held reset request after a stop in reset mode |

## Verification
Two pairs of actions can land in the same backup-clock cycle as a detected stop: a software write of the selector against the hardware failover force, and a flag-clear strobe against the hardware set of the detect flag. The bench provokes both at once. It keeps `cfg_wr` high (selector 2'b00) and `det_clr` high on every cycle while the main clock dies, so both strobes are active in the cycle of the stop event. On the sample where the interrupt pulse is seen, it requires the selector to read backup and the detect flag to read 1. It then drops both strobes and confirms that the flag stays set.

// File: rtl/clm_pkg.sv
package clm_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN   = 2'b00,
        SRC_PLL    = 2'b01,
        SRC_BACKUP = 2'b10
    } clk_src_e;

    typedef enum logic [1:0] {
        MON_OFF  = 2'b00,
        MON_RUN  = 2'b01,
        MON_LOST = 2'b10,
        MON_HALT = 2'b11
    } mon_state_e;

endpackage

// File: rtl/clm_edge_sync.sv
module clm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic main_clk,
    input  logic bk_clk,
    input  logic rst_n,
    output logic edge_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic               tgl_q;
    logic [CHAIN_W-1:0] chain_q;

    // divide-by-two marker in the main domain
    always_ff @(posedge main_clk or negedge rst_n) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= ~tgl_q;
    end

    // synchronizer stages plus one history flop
    always_ff @(posedge bk_clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], tgl_q};
    end

    assign edge_o = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];

endmodule

// File: rtl/clm_fsm.sv
module clm_fsm
    import clm_pkg::*;
#(
    parameter int STOP_CYC      = 8,
    parameter int RESTART_EDGES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       mode_i,
    input  logic       edge_i,
    output mon_state_e state_o,
    output logic       stop_ev_o,
    output logic       restart_ev_o
);
    localparam int GW = $clog2(STOP_CYC);
    localparam int EW = $clog2(RESTART_EDGES);
    localparam logic [GW-1:0] GAP_LAST  = GW'(STOP_CYC - 1);
    localparam logic [EW-1:0] ECNT_LAST = EW'(RESTART_EDGES - 1);

    mon_state_e    state_q, state_d;
    logic [GW-1:0] gap_q, gap_d;
    logic [EW-1:0] ecnt_q, ecnt_d;
    logic          gap_hit;

    assign gap_hit = !edge_i && (gap_q == GAP_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_OFF;
            gap_q   <= '0;
            ecnt_q  <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
            ecnt_q  <= ecnt_d;
        end
    end

    // next state and events
    always_comb begin
        state_d      = state_q;
        stop_ev_o    = 1'b0;
        restart_ev_o = 1'b0;
        unique case (state_q)
            MON_OFF: begin
                if (en_i) state_d = MON_RUN;
            end
            MON_RUN: begin
                if (!en_i) begin
                    state_d = MON_OFF;
                end else if (gap_hit) begin
                    stop_ev_o = 1'b1;
                    state_d   = mode_i ? MON_LOST : MON_HALT;
                end
            end
            MON_LOST: begin
                if (!en_i) begin
                    state_d = MON_OFF;
                end else if (edge_i && (ecnt_q == ECNT_LAST)) begin
                    restart_ev_o = 1'b1;
                    state_d      = mode_i ? MON_RUN : MON_HALT;
                end
            end
            MON_HALT: begin
                state_d = MON_HALT;
            end
        endcase
    end

    // gap and edge counters
    always_comb begin
        gap_d  = '0;
        ecnt_d = '0;
        if ((state_q == MON_RUN || state_q == MON_LOST) && (state_d == state_q)) begin
            if (!edge_i && !gap_hit) gap_d = gap_q + 1'b1;
            if (state_q == MON_LOST && !gap_hit)
                ecnt_d = edge_i ? ecnt_q + 1'b1 : ecnt_q;
        end
    end

    assign state_o = state_q;

    // R3: an edge restarts the gap count, so no stop can follow it directly
    a_r3_no_stop_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> !stop_ev_o);

    // R8: reset mode must not be active while the monitor sits in the lost state
    a_r8_no_reset_mode_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MON_LOST && en_i) |-> mode_i);

    // R8: halt is left only through hardware reset
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MON_HALT) |=> (state_q == MON_HALT));

    // R3: stop and restart never fire together
    a_r3_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_ev_o && restart_ev_o));

endmodule

// File: rtl/clm_ctrl.sv
module clm_ctrl
    import clm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_en,
    input  logic       cfg_mode,
    input  logic [1:0] cfg_src,
    input  logic       det_clr,
    input  logic       stop_ev,
    input  logic       restart_ev,
    input  logic       halt,
    output logic       en_o,
    output logic       mode_o,
    output logic [1:0] src_o,
    output logic       det_o,
    output logic       irq_o
);
    logic       en_q, mode_q, det_q, irq_q;
    logic [1:0] src_q;
    logic       int_ev;

    assign int_ev = (stop_ev || restart_ev) && mode_q && en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            src_q  <= SRC_MAIN;
            det_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= int_ev;
            if (!halt) begin
                if (cfg_wr) begin
                    en_q   <= cfg_en;
                    mode_q <= cfg_mode;
                    src_q  <= cfg_src;
                end
                if (det_clr) det_q <= 1'b0;
            end
            // hardware updates placed last so they win
            if (int_ev) det_q <= 1'b1;
            if (int_ev && stop_ev && src_q == SRC_MAIN) src_q <= SRC_BACKUP;
        end
    end

    assign en_o   = en_q;
    assign mode_o = mode_q;
    assign src_o  = src_q;
    assign det_o  = det_q;
    assign irq_o  = irq_q;

    // R4: interrupt is a single-cycle pulse
    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R2: a disabled monitor raises no interrupt
    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !irq_o);

    // R9: every interrupt is visible in the detect flag
    a_r9_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> det_o);

    // R5 / R10: failover to backup after a stop on the main source
    a_r10_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && mode_q && en_q && src_q == SRC_MAIN) |=> (src_o == SRC_BACKUP));

    // R7: restart without a write keeps the selector
    a_r7_restart_keeps_src: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_ev && !cfg_wr) |=> $stable(src_o));

    // R8: configuration frozen while halted
    a_r8_frozen_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> ($stable(en_o) && $stable(mode_o)));

endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
    import clm_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STOP_CYC      = 8,
    parameter int RESTART_EDGES = 4
) (
    input  logic       bk_clk,
    input  logic       rst_n,
    input  logic       main_clk,
    input  logic       cfg_wr,
    input  logic       cfg_en,
    input  logic       cfg_mode,
    input  logic [1:0] cfg_src,
    input  logic       det_clr,
    output logic       mon_en,
    output logic       mon_mode,
    output logic [1:0] src_sel,
    output logic       det_flag,
    output logic       main_stopped,
    output logic       osc_irq,
    output logic       sys_rst_req
);
    logic       main_edge;
    mon_state_e state;
    logic       stop_ev, restart_ev;

    clm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .main_clk (main_clk),
        .bk_clk   (bk_clk),
        .rst_n    (rst_n),
        .edge_o   (main_edge)
    );

    clm_fsm #(.STOP_CYC(STOP_CYC), .RESTART_EDGES(RESTART_EDGES)) fsm_i (
        .clk          (bk_clk),
        .rst_n        (rst_n),
        .en_i         (mon_en),
        .mode_i       (mon_mode),
        .edge_i       (main_edge),
        .state_o      (state),
        .stop_ev_o    (stop_ev),
        .restart_ev_o (restart_ev)
    );

    clm_ctrl ctrl_i (
        .clk        (bk_clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_en     (cfg_en),
        .cfg_mode   (cfg_mode),
        .cfg_src    (cfg_src),
        .det_clr    (det_clr),
        .stop_ev    (stop_ev),
        .restart_ev (restart_ev),
        .halt       (sys_rst_req),
        .en_o       (mon_en),
        .mode_o     (mon_mode),
        .src_o      (src_sel),
        .det_o      (det_flag),
        .irq_o      (osc_irq)
    );

    assign main_stopped = (state == MON_LOST);
    assign sys_rst_req  = (state == MON_HALT);

    // R11: leaving enable drops the stopped flag within two cycles
    a_r11_disable_clears_stop: assert property (@(posedge bk_clk) disable iff (!rst_n)
        (!mon_en && main_stopped) |=> !main_stopped);

endmodule

// File: tb/clk_loss_monitor_tb_top.sv
`timescale 1ns/1ps
module clk_loss_monitor_tb_top;

    logic       bk_clk = 1'b0;
    logic       main_clk = 1'b0;
    logic       main_run = 1'b1;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_en = 1'b0, cfg_mode = 1'b0, det_clr = 1'b0;
    logic [1:0] cfg_src = 2'b00;
    logic       mon_en, mon_mode, det_flag, main_stopped, osc_irq, sys_rst_req;
    logic [1:0] src_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 bk_clk = ~bk_clk;

    always begin
        #5;
        if (main_run) main_clk = ~main_clk;
        else          main_clk = 1'b0;
    end

    clk_loss_monitor dut_i (
        .bk_clk(bk_clk), .rst_n(rst_n), .main_clk(main_clk),
        .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_src(cfg_src),
        .det_clr(det_clr), .mon_en(mon_en), .mon_mode(mon_mode), .src_sel(src_sel),
        .det_flag(det_flag), .main_stopped(main_stopped), .osc_irq(osc_irq),
        .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge bk_clk);
    endtask

    task automatic sw_write(input logic en, input logic mode, input logic [1:0] src);
        @(negedge bk_clk);
        cfg_wr = 1'b1; cfg_en = en; cfg_mode = mode; cfg_src = src;
        @(negedge bk_clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_det();
        @(negedge bk_clk);
        det_clr = 1'b1;
        @(negedge bk_clk);
        det_clr = 1'b0;
    endtask

    // returns the cycle count at which osc_irq was seen, 999 if not seen
    task automatic wait_irq(input int max, output int cyc);
        cyc = 999;
        for (int i = 1; i <= max; i++) begin
            @(negedge bk_clk);
            if (osc_irq) begin
                cyc = i;
                break;
            end
        end
    endtask

    task automatic count_irq(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge bk_clk);
            if (osc_irq) cnt++;
        end
    endtask

    task automatic t_reset();
        chk("R1 mon_en", mon_en, 0);
        chk("R1 mon_mode", mon_mode, 0);
        chk("R1 src_sel", src_sel, 0);
        chk("R1 det_flag", det_flag, 0);
        chk("R1 main_stopped", main_stopped, 0);
        chk("R1 osc_irq", osc_irq, 0);
        chk("R1 sys_rst_req", sys_rst_req, 0);
    endtask

    task automatic t_disabled();
        int cnt;
        main_run = 1'b0;
        count_irq(40, cnt);
        chk("R2 irq while disabled (stop)", cnt, 0);
        chk("R2 stopped while disabled", main_stopped, 0);
        chk("R2 det while disabled", det_flag, 0);
        chk("R2 reset req while disabled", sys_rst_req, 0);
        main_run = 1'b1;
        count_irq(40, cnt);
        chk("R2 irq while disabled (restart)", cnt, 0);
    endtask

    task automatic t_stop_main();
        int cyc, cnt;
        sw_write(1'b1, 1'b1, 2'b00);
        count_irq(30, cnt);
        chk("R3 no stop with main running", cnt, 0);
        main_run = 1'b0;
        wait_irq(40, cyc);
        chk_range("R3 stop declaration delay", cyc, 9, 20);
        chk("R4 det after stop", det_flag, 1);
        chk("R4 stopped after stop", main_stopped, 1);
        chk("R5 src forced to backup", src_sel, 2);
        count_irq(20, cnt);
        chk("R4 single irq per stop", cnt, 0);
    endtask

    task automatic t_restart();
        int cyc;
        clear_det();
        chk("R9 det cleared by strobe", det_flag, 0);
        main_run = 1'b1;
        wait_irq(40, cyc);
        chk_range("R7 restart delay", cyc, 5, 30);
        chk("R7 det after restart", det_flag, 1);
        chk("R7 stopped cleared", main_stopped, 0);
        chk("R7 src unchanged", src_sel, 2);
    endtask

    task automatic t_pll();
        int cyc;
        clear_det();
        sw_write(1'b1, 1'b1, 2'b01);
        tick(20);
        main_run = 1'b0;
        wait_irq(40, cyc);
        chk_range("R6 stop seen on pll source", cyc, 9, 20);
        chk("R6 src stays pll", src_sel, 1);
        chk("R6 stopped flag", main_stopped, 1);
        sw_write(1'b1, 1'b1, 2'b10);
        chk("R10 software selector write", src_sel, 2);
        main_run = 1'b1;
        wait_irq(40, cyc);
        chk_range("R7 restart on pll test", cyc, 5, 30);
        tick(5);
    endtask

    task automatic t_collide();
        int cyc;
        sw_write(1'b1, 1'b1, 2'b00);
        tick(20);
        @(negedge bk_clk);
        main_run = 1'b0;
        cfg_wr = 1'b1; cfg_en = 1'b1; cfg_mode = 1'b1; cfg_src = 2'b00;
        det_clr = 1'b1;
        wait_irq(40, cyc);
        chk_range("R10 collision stop seen", cyc, 9, 20);
        chk("R10 force beats software write", src_sel, 2);
        chk("R9 set beats clear", det_flag, 1);
        cfg_wr = 1'b0;
        det_clr = 1'b0;
        tick(2);
        chk("R9 flag stays set after collision", det_flag, 1);
        main_run = 1'b1;
        wait_irq(40, cyc);
        chk_range("R7 restart after collision", cyc, 5, 30);
    endtask

    task automatic t_disable_lost();
        int cyc, cnt;
        main_run = 1'b0;
        wait_irq(40, cyc);
        chk("R11 stopped before disable", main_stopped, 1);
        sw_write(1'b0, 1'b1, 2'b10);
        tick(2);
        chk("R11 stopped cleared by disable", main_stopped, 0);
        main_run = 1'b1;
        count_irq(40, cnt);
        chk("R11 no irq on restart when disabled", cnt, 0);
        chk("R2 det untouched while disabled", det_flag, 1);
    endtask

    task automatic t_reset_mode();
        int cnt;
        sw_write(1'b1, 1'b0, 2'b00);
        tick(20);
        chk("R8 no reset with main running", sys_rst_req, 0);
        main_run = 1'b0;
        count_irq(40, cnt);
        chk("R8 reset request raised", sys_rst_req, 1);
        chk("R8 no irq in reset mode", cnt, 0);
        sw_write(1'b0, 1'b1, 2'b01);
        chk("R8 enable frozen", mon_en, 1);
        chk("R8 mode frozen", mon_mode, 0);
        main_run = 1'b1;
        tick(40);
        chk("R8 request held after restart", sys_rst_req, 1);
        @(negedge bk_clk);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R8 request released by reset", sys_rst_req, 0);
        chk("R1 enable after second reset", mon_en, 0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_disabled();
        t_stop_main();
        t_restart();
        t_pll();
        t_collide();
        t_disable_lost();
        t_reset_mode();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule